// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous SRAM that has a small on-chip array and a fixed two-stage address-to-data pipeline. The block samples address, read/write select, byte-lane write enables and the access strobe on a rising clock edge. The data side of that access follows two enabled edges later. Reads and writes use the same pipeline depth, so the data path never needs an idle turnaround cycle when the direction changes. Any mix of reads and writes can be issued on consecutive cycles.

The block has separate write-data and read-data buses. A drive flag stands in for a tri-state pin and tells the surrounding logic when the read-data bus carries valid data. An active-low clock enable stalls the whole block. Three chip enables qualify each new access. An asynchronous output enable can blank the read side in any cycle. In this block, an advance cycle (strobe high) starts no access, because burst sequencing is handled by a separate block.

Top module: `ztsram_core`

## Requirements
- R1: An access sampled at enabled edge E completes at enabled edge E+2. A write stores `wdata` sampled at E+2. A read places the word on `rdata` and sets `rdata_drv` from E+2 until the next enabled edge.
- R2: Reads and writes may be issued on every enabled edge in any order, with no idle cycle needed between a write and a read or between a read and a write.
- R3: While `cke_n` is 1, all inputs are ignored and every internal register, including the array, keeps its value, so `rdata` and `rdata_drv` hold.
- R4: A new access starts only when `ld_n`=0, `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination, including `ld_n`=1, starts nothing.
- R5: An access already in the pipeline completes normally even if the device is deselected on the following edges.
- R6: At enabled edge E+2, `rdata_drv` falls when the slot sampled at E was a write or started no access.
- R7: `rd_wr`=1 selects a read and 0 selects a write. `byte_we_n[i]`=0 writes lane i (bits 9i+8 down to 9i), and lanes with 1 keep their old content. The lane mask is sampled with the address, not with the data.
- R8: `oe_n`=1 forces `rdata_drv` to 0 and `rdata` to zero combinationally. The pending read data is not disturbed and reappears when `oe_n` returns to 0.
- R9: A read returns the latest write to its address, including a write issued one or two edges earlier.
- R10: A synchronous reset (`rst_n`=0) discards all pending accesses and clears `rdata_drv`. Array contents are kept.
- R11: `rdata` is all zeros whenever `rdata_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; 1 stalls the block |
| addr | input | AW (8) | Word address |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ld_n | input | 1 | Active-low strobe: 0 starts a new access |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| byte_we_n | input | LANES (4) | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | DW (36) | Write data for the data phase |
| rdata | output | DW (36) | Read data, zero when not driven |
| rdata_drv | output | 1 | Read data valid / bus-drive flag |

## Verification
On every cycle, the checker confirms that a stall leaves the pipeline and output registers unchanged, and that a cycle without a proper strobe and enables puts no access into the pipeline. It also confirms that a pending access always advances even when the device is deselected, that the drive flag follows the kind of access in the last stage, and that output enable blanks the drive flag. Only the bench scenarios can show the data itself. These cover byte-lane merging of a partial write, a read issued right after a write returning the new data, a stalled write being ignored, each chip-enable polarity refusing an access, and array contents surviving a reset.

// File: rtl/ztsram_pkg.sv
// Shared definitions for the zero-turnaround SRAM model.
// Assumes a fixed two-stage address-to-data pipeline.
package ztsram_pkg;
    localparam int unsigned PIPE_STAGES = 2;

    // One pipeline slot: does it carry an access, and is it a read
    typedef struct packed {
        logic vld;
        logic rd;
    } op_t;
endpackage

// File: rtl/ztsram_issue.sv
// Access qualifier: decides whether the sampled inputs start a new access.
// Assumes the enable polarities are fixed (a low, b high, c low).
module ztsram_issue
    import ztsram_pkg::*;
(
    input  logic ld_n,
    input  logic cs_a_n,
    input  logic cs_b,
    input  logic cs_c_n,
    input  logic rd_wr,
    output op_t  op
);
    logic selected;

    // All three enables active and the load strobe low
    always_comb begin
        selected = !cs_a_n && cs_b && !cs_c_n;
        op.vld   = selected && !ld_n;
        op.rd    = rd_wr;
    end
endmodule

// File: rtl/ztsram_pipe.sv
// Address/control pipeline: carries op, address and lane mask through
// PIPE_STAGES registers. Advances only when en is high; reset empties it.
module ztsram_pipe
    import ztsram_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  op_t              in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_mask_n,
    output op_t              head_op,
    output op_t              tail_op,
    output logic [AW-1:0]    tail_addr,
    output logic [LANES-1:0] tail_mask_n
);
    op_t              op_q   [PIPE_STAGES];
    logic [AW-1:0]    addr_q [PIPE_STAGES];
    logic [LANES-1:0] mask_q [PIPE_STAGES];

    for (genvar s = 0; s < PIPE_STAGES; s++) begin : g_stage
        op_t              nxt_op;
        logic [AW-1:0]    nxt_addr;
        logic [LANES-1:0] nxt_mask;

        // Pick the stage source: block inputs or the previous stage
        if (s == 0) begin : g_first
            always_comb begin
                nxt_op   = in_op;
                nxt_addr = in_addr;
                nxt_mask = in_mask_n;
            end
        end else begin : g_next
            always_comb begin
                nxt_op   = op_q[s-1];
                nxt_addr = addr_q[s-1];
                nxt_mask = mask_q[s-1];
            end
        end

        // Stage register, held while the clock enable is off
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_q[s]   <= '0;
                addr_q[s] <= '0;
                mask_q[s] <= '1;
            end else if (en) begin
                op_q[s]   <= nxt_op;
                addr_q[s] <= nxt_addr;
                mask_q[s] <= nxt_mask;
            end
        end
    end

    assign head_op     = op_q[0];
    assign tail_op     = op_q[PIPE_STAGES-1];
    assign tail_addr   = addr_q[PIPE_STAGES-1];
    assign tail_mask_n = mask_q[PIPE_STAGES-1];
endmodule

// File: rtl/ztsram_array.sv
// Byte-lane storage array with a registered read port.
// One memory per lane, so each lane's write enable is independent.
// Assumes at most one access (read or write) per enabled edge.
module ztsram_array #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr,
    input  logic             rd,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] mask_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane write when the lane enable is low
        always_ff @(posedge clk) begin
            if (en && wr && !mask_n[l]) begin
                mem[addr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        // Lane read register, updated only by a read
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else if (en && rd) begin
                rd_q <= mem[addr];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/ztsram_core.sv
// Zero-turnaround pipelined SRAM. Accesses sampled at edge E finish at
// enabled edge E+2 for reads and writes alike. cke_n stalls everything;
// oe_n gates the read side combinationally. Burst sequencing is external.
module ztsram_core
    import ztsram_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic [AW-1:0]    addr,
    input  logic             rd_wr,
    input  logic             ld_n,
    input  logic             cs_a_n,
    input  logic             cs_b,
    input  logic             cs_c_n,
    input  logic [LANES-1:0] byte_we_n,
    input  logic             oe_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_drv
);
    logic             en;
    op_t              new_op;
    op_t              head_op;
    op_t              tail_op;
    logic [AW-1:0]    tail_addr;
    logic [LANES-1:0] tail_mask_n;
    logic             s1_vld;
    logic             s2_vld;
    logic             s2_rd;
    logic             drv_q;
    logic [DW-1:0]    dout_q;

    assign en = !cke_n;

    ztsram_issue u_issue (
        .ld_n   (ld_n),
        .cs_a_n (cs_a_n),
        .cs_b   (cs_b),
        .cs_c_n (cs_c_n),
        .rd_wr  (rd_wr),
        .op     (new_op)
    );

    ztsram_pipe #(.AW(AW), .LANES(LANES)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .in_op       (new_op),
        .in_addr     (addr),
        .in_mask_n   (byte_we_n),
        .head_op     (head_op),
        .tail_op     (tail_op),
        .tail_addr   (tail_addr),
        .tail_mask_n (tail_mask_n)
    );

    assign s1_vld = head_op.vld;
    assign s2_vld = tail_op.vld;
    assign s2_rd  = tail_op.rd;

    ztsram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .wr     (s2_vld && !s2_rd),
        .rd     (s2_vld && s2_rd),
        .addr   (tail_addr),
        .mask_n (tail_mask_n),
        .wdata  (wdata),
        .rdata  (dout_q)
    );

    // Drive flag: set for the data phase of a read, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
        end else if (en) begin
            drv_q <= s2_vld && s2_rd;
        end
    end

    // Asynchronous output gating by oe_n
    always_comb begin
        rdata_drv = drv_q && !oe_n;
        rdata     = rdata_drv ? dout_q : '0;
    end
endmodule

// File: rtl/ztsram_chk.sv
// Property checker for ztsram_core, attached by bind below.
// Observes ports and pipeline state; drives nothing.
module ztsram_chk (
    input logic clk,
    input logic rst_n,
    input logic cke_n,
    input logic ld_n,
    input logic cs_a_n,
    input logic cs_b,
    input logic cs_c_n,
    input logic oe_n,
    input logic rdata_drv,
    input logic s1_vld,
    input logic s2_vld,
    input logic s2_rd,
    input logic drv_q
);
    // R3: a stall freezes pipeline and drive state
    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(s1_vld) && $stable(s2_vld) && $stable(drv_q));

    // R4: no access enters without strobe and all enables
    a_r4_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && (ld_n || cs_a_n || !cs_b || cs_c_n)) |=> !s1_vld);

    // R5: a pending access always moves to the data stage
    a_r5_pending_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_vld) |=> s2_vld);

    // R1: a read in the last stage drives data after the next enabled edge
    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_vld && s2_rd) |=> drv_q);

    // R6: a write or empty slot stops the drive
    a_r6_drive_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !(s2_vld && s2_rd)) |=> !drv_q);

    // R8: output enable high blanks the drive flag
    a_r8_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_drv);
endmodule

bind ztsram_core ztsram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .ld_n      (ld_n),
    .cs_a_n    (cs_a_n),
    .cs_b      (cs_b),
    .cs_c_n    (cs_c_n),
    .oe_n      (oe_n),
    .rdata_drv (rdata_drv),
    .s1_vld    (s1_vld),
    .s2_vld    (s2_vld),
    .s2_rd     (s2_rd),
    .drv_q     (drv_q)
);

// File: tb/ztsram_core_test.sv
`timescale 1ns/1ps
// Bench for ztsram_core: a cycle table walked by one loop, then directed
// tests for output enable and reset. Inputs change on the falling edge and
// outputs are sampled 1 ns after the rising edge.
module ztsram_core_test;
    localparam int unsigned AW = 8;
    localparam int unsigned LN = 4;
    localparam int unsigned DW = 36;
    localparam logic [2:0]  SEL = 3'b010; // {cs_a_n, cs_b, cs_c_n}

    localparam logic [DW-1:0] D1 = 36'h123456789;
    localparam logic [DW-1:0] D2 = 36'h987654321;
    localparam logic [DW-1:0] D3 = 36'hFFFFFFFFF;
    localparam logic [DW-1:0] DP = 36'h12347FFFF; // D1 with lanes 0,1 from D3
    localparam logic [DW-1:0] D4 = 36'h00F0F0F0F;
    localparam logic [DW-1:0] D5 = 36'h5A5A5A5A5;

    typedef struct packed {
        logic          cke_n;
        logic          ld_n;
        logic [2:0]    cs;
        logic          rd;
        logic [AW-1:0] a;
        logic [LN-1:0] be_n;
        logic [DW-1:0] wd;
        logic          x_drv;
        logic [DW-1:0] x_dat;
        logic [3:0]    req;
    } vec_t;

    // Each row is one edge; expected values are the outputs after that edge
    localparam vec_t VEC [0:16] = '{
        '{1'b0, 1'b0, SEL,    1'b0, 8'd5, 4'h0,    '0, 1'b0, '0, 4'd1},  // R1 write 5
        '{1'b0, 1'b0, SEL,    1'b0, 8'd6, 4'h0,    '0, 1'b0, '0, 4'd2},  // R2 write 6
        '{1'b0, 1'b0, SEL,    1'b1, 8'd5, 4'hF,    D1, 1'b0, '0, 4'd2},  // R2 read 5, data of write 5
        '{1'b0, 1'b0, SEL,    1'b1, 8'd6, 4'hF,    D2, 1'b0, '0, 4'd6},  // R6 write slot: no drive
        '{1'b0, 1'b0, SEL,    1'b0, 8'd5, 4'b1100, '0, 1'b1, D1, 4'd1},  // R1 read 5; R7 lanes 0,1 write
        '{1'b0, 1'b0, SEL,    1'b1, 8'd5, 4'hF,    '0, 1'b1, D2, 4'd2},  // R2 read 6 back-to-back
        '{1'b0, 1'b0, 3'b110, 1'b1, 8'd6, 4'hF,    D3, 1'b0, '0, 4'd6},  // R6 partial write data
        '{1'b0, 1'b1, SEL,    1'b0, 8'd6, 4'h0,    '0, 1'b1, DP, 4'd7},  // R7 merged lanes; R4 ld_n high
        '{1'b1, 1'b0, SEL,    1'b0, 8'd6, 4'h0,    '0, 1'b1, DP, 4'd3},  // R3 stall holds output
        '{1'b0, 1'b0, SEL,    1'b1, 8'd6, 4'hF,    D3, 1'b0, '0, 4'd4},  // R4 deselected slot
        '{1'b0, 1'b0, 3'b000, 1'b1, 8'd6, 4'hF,    '0, 1'b0, '0, 4'd4},  // R4 advance slot empty
        '{1'b0, 1'b0, SEL,    1'b1, 8'd5, 4'hF,    '0, 1'b1, D2, 4'd5},  // R5 read 6 completes after deselect
        '{1'b0, 1'b0, SEL,    1'b0, 8'd6, 4'h0,    '0, 1'b0, '0, 4'd4},  // R4 cs_b low slot empty
        '{1'b0, 1'b0, SEL,    1'b1, 8'd6, 4'hF,    '0, 1'b1, DP, 4'd2},  // R2 read then write then read
        '{1'b0, 1'b0, 3'b011, 1'b1, 8'd5, 4'hF,    D4, 1'b0, '0, 4'd6},  // R6 write 6 data
        '{1'b0, 1'b0, 3'b100, 1'b1, 8'd5, 4'hF,    '0, 1'b1, D4, 4'd9},  // R9 read right after write
        '{1'b0, 1'b0, 3'b110, 1'b0, 8'd5, 4'h0,    '0, 1'b0, '0, 4'd4}   // R4 cs_c_n high slot empty
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_wr = 1'b0;
    logic          ld_n = 1'b1;
    logic          cs_a_n = 1'b1;
    logic          cs_b = 1'b0;
    logic          cs_c_n = 1'b1;
    logic [LN-1:0] byte_we_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ztsram_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .addr      (addr),
        .rd_wr     (rd_wr),
        .ld_n      (ld_n),
        .cs_a_n    (cs_a_n),
        .cs_b      (cs_b),
        .cs_c_n    (cs_c_n),
        .byte_we_n (byte_we_n),
        .oe_n      (oe_n),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_drv (rdata_drv)
    );

    task automatic check(input string req, input logic drv_x, input logic [DW-1:0] dat_x);
        checks++;
        if (rdata_drv !== drv_x || rdata !== dat_x) begin
            errors++;
            $display("FAIL %s: drv=%0b rdata=%h expected drv=%0b rdata=%h",
                     req, rdata_drv, rdata, drv_x, dat_x);
        end
    endtask

    task automatic put(input logic ck, input logic ld, input logic [2:0] cs,
                       input logic rd, input logic [AW-1:0] a,
                       input logic [LN-1:0] be, input logic [DW-1:0] wd);
        @(negedge clk);
        cke_n = ck; ld_n = ld; {cs_a_n, cs_b, cs_c_n} = cs;
        rd_wr = rd; addr = a; byte_we_n = be; wdata = wd;
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) edge_wait();
        check("R10 reset state", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i <= 16; i++) begin
            put(VEC[i].cke_n, VEC[i].ld_n, VEC[i].cs, VEC[i].rd,
                VEC[i].a, VEC[i].be_n, VEC[i].wd);
            edge_wait();
            check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].x_drv, VEC[i].x_dat);
        end

        // R8: output enable blanks and restores without disturbing the pipe
        put(1'b0, 1'b0, SEL, 1'b0, 8'd9, 4'h0, '0); edge_wait();
        put(1'b0, 1'b0, 3'b110, 1'b0, 8'd9, 4'h0, '0); edge_wait();
        put(1'b0, 1'b0, SEL, 1'b1, 8'd9, 4'hF, D5); edge_wait();
        put(1'b0, 1'b0, 3'b110, 1'b0, 8'd0, 4'hF, '0); edge_wait();
        put(1'b0, 1'b0, 3'b110, 1'b0, 8'd0, 4'hF, '0); edge_wait();
        check("R8 read with oe_n low", 1'b1, D5);
        oe_n = 1'b1;
        #0.5;
        check("R8 oe_n high blanks", 1'b0, '0);
        oe_n = 1'b0;
        #0.5;
        check("R8 oe_n restored", 1'b1, D5);
        edge_wait();
        check("R11 idle output zero", 1'b0, '0);

        // R10: reset drops a pending read but keeps the array
        put(1'b0, 1'b0, SEL, 1'b1, 8'd9, 4'hF, '0); edge_wait();
        put(1'b0, 1'b0, 3'b110, 1'b0, 8'd0, 4'hF, '0);
        rst_n = 1'b0;
        edge_wait();
        @(negedge clk);
        rst_n = 1'b1;
        edge_wait();
        check("R10 pending read discarded", 1'b0, '0);
        put(1'b0, 1'b0, SEL, 1'b1, 8'd9, 4'hF, '0); edge_wait();
        put(1'b0, 1'b0, 3'b110, 1'b0, 8'd0, 4'hF, '0); edge_wait();
        check("R10 pipe empty one edge after issue", 1'b0, '0);
        edge_wait();
        check("R10 array kept across reset", 1'b1, D5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule